// File: doc/BRIEF.md
# I2C Bus Condition Detector and Byte Shifter

This block sits between the raw I2C pins and a node's control logic. It passes SCL and SDA through a multi-flop synchronizer and watches the synchronized levels for bus conditions. It reports a START on an idle bus, a repeated START inside a frame, and a STOP, each on its own single-cycle strobe. While the host sleeps, any such condition also raises a wake strobe.

A byte-wide shift register moves data in both directions, most significant bit first. When the node receives, the register collects the eight data bits. The ninth (acknowledge) slot is then driven from a control input. When the node transmits, the register drives the byte onto SDA through an open-drain pull-down, and the acknowledge bit returned by the far end is reported with its own strobe. Serving as a bus master transmitter, the block compares every released bit against the bus. If it loses arbitration, it reports a pulse and stops pulling SDA until the next START or STOP.

Clock generation on SCL and protocol sequencing belong to the surrounding control logic.

Top module: `i2cfe_front`

## Requirements
- R1: SDA falling while SCL is high on an idle bus (no START since the last STOP or reset) gives one `start_o` pulse and marks the bus busy.
- R2: SDA falling while SCL is high on a busy bus gives one `rstart_o` pulse and no `start_o` pulse.
- R3: SDA rising while SCL is high gives one `stop_o` pulse and returns the bus to idle. In the cycle after `stop_o` the block does not pull SDA low.
- R4: At most one of `start_o`, `rstart_o` and `stop_o` is high in any cycle, and each is a single-cycle pulse.
- R5: `wake_o` pulses together with any condition strobe while `low_power_i` is 1. It stays low while `low_power_i` is 0.
- R6: A frame begins at the first SCL falling edge after a START or repeated START. Data is sampled on SCL rising edges, most significant bit first. At the falling edge ending the eighth bit, `rx_valid_o` pulses and `rx_byte_o` holds the byte seen on the bus.
- R7: In receive mode (`tx_en_i` = 0) the block pulls SDA low only during the ninth bit, and only when `ack_en_i` = 1 (a low ninth bit means ACK).
- R8: In transmit mode (`tx_en_i` = 1), a byte loaded with `tx_load_i` is driven MSB first: the block pulls SDA low for 0 bits and releases it for 1 bits. The ninth bit is released. At its falling edge `ack_valid_o` pulses and `ack_bit_o` holds the sampled level (0 = ACK). The block does not drive again until the next load.
- R9: With `master_en_i` = 1 and `tx_en_i` = 1, a released data bit sampled low on an SCL rise pulses `arb_lost_o`. The block then releases SDA for the rest of the frame, until the next START, repeated START or STOP. With `master_en_i` = 0 no loss is reported.
- R10: SDA transitions while SCL is low, and SCL transitions, produce no condition strobe.
- R11: After reset all strobes are low and SDA is not pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pin |
| sda_i | input | 1 | Raw SDA level from the pin |
| low_power_i | input | 1 | Host is in a low-power state |
| tx_en_i | input | 1 | 1: node transmits data bytes; 0: node receives |
| master_en_i | input | 1 | Node is bus master; enables arbitration checking |
| ack_en_i | input | 1 | Receive mode: 1 acknowledges (pulls the ninth bit low) |
| tx_load_i | input | 1 | Load `tx_byte_i` into the shift register |
| tx_byte_i | input | DATA_W | Byte to transmit |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| start_o | output | 1 | START strobe |
| rstart_o | output | 1 | Repeated START strobe |
| stop_o | output | 1 | STOP strobe |
| wake_o | output | 1 | Wake strobe while in low power |
| rx_byte_o | output | DATA_W | Byte seen on the bus |
| rx_valid_o | output | 1 | Strobe: `rx_byte_o` complete |
| ack_bit_o | output | 1 | Sampled ninth bit (0 = ACK) |
| ack_valid_o | output | 1 | Strobe: `ack_bit_o` updated |
| arb_lost_o | output | 1 | Arbitration-lost pulse |

## Verification
Every byte value from 0x00 to 0xFF is received, with the acknowledge control alternating. This separates a correct MSB-first capture from bit-order or off-by-one shifting faults, and shows whether the ninth-bit pull-down follows the control input. Every value is also transmitted against a fully released bus with alternating far-end acknowledges, which checks drive polarity and acknowledge reporting. A frame with a repeated START, SDA toggling under a low SCL, and a low-power pass with wake counting show whether the condition logic tells a START from a repeated START and ignores data transitions. Two competing-master runs are made: one where the node is master, in which the bus must carry the winner's byte after the loss, and one where it is not, in which the bus must carry the wired-AND of both bytes.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
   // one-hot view of the bus conditions seen in a cycle
   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
   } cond_t;

   localparam logic BUS_IDLE_LVL = 1'b1;
endpackage

// File: rtl/i2cfe_sync.sv
module i2cfe_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cfe_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("i2cfe_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= {WIDTH{RST_LVL}};
               else        pipe[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= {WIDTH{RST_LVL}};
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2cfe_cond.sv
module i2cfe_cond
   import i2cfe_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_s,
   input  logic  sda_s,
   output cond_t cond_o,
   output logic  scl_rise_o,
   output logic  scl_fall_o
);
   logic scl_q, sda_q, busy_q;
   logic scl_held, sda_fall_hi, sda_rise_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= BUS_IDLE_LVL;
         sda_q  <= BUS_IDLE_LVL;
         busy_q <= 1'b0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (sda_fall_hi)      busy_q <= 1'b1;
         else if (sda_rise_hi) busy_q <= 1'b0;
      end
   end

   // SCL must be high on both sides of the SDA edge
   assign scl_held    = scl_s & scl_q;
   assign sda_fall_hi = scl_held & sda_q & ~sda_s;
   assign sda_rise_hi = scl_held & ~sda_q & sda_s;

   assign cond_o.start  = sda_fall_hi & ~busy_q;
   assign cond_o.rstart = sda_fall_hi & busy_q;
   assign cond_o.stop   = sda_rise_hi;

   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
endmodule

// File: rtl/i2cfe_shift.sv
module i2cfe_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              frame_clr,
   input  logic              tx_en,
   input  logic              master_en,
   input  logic              ack_en,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              sda_low,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              ack_bit,
   output logic              ack_valid,
   output logic              arb_lost
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W - 1);
   localparam logic [CW-1:0] ACK_SLOT  = CW'(DATA_W);

   logic [DATA_W-1:0] shreg;
   logic [CW-1:0]     bit_cnt;
   logic              framed, tx_full, lost, samp;
   logic              in_data, bit_end, drive_tx, drive_ack;

   assign in_data = framed & (bit_cnt < ACK_SLOT);
   assign bit_end = scl_fall & framed;

   // released data bit read back low while arbitrating
   assign arb_lost = scl_rise & master_en & tx_en & tx_full & ~lost
                   & in_data & shreg[DATA_W-1] & ~sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         framed    <= 1'b0;
         tx_full   <= 1'b0;
         lost      <= 1'b0;
         samp      <= 1'b1;
         rx_valid  <= 1'b0;
         ack_bit   <= 1'b1;
         ack_valid <= 1'b0;
      end else begin
         rx_valid  <= 1'b0;
         ack_valid <= 1'b0;
         if (scl_rise) samp <= sda_s;
         if (arb_lost) lost <= 1'b1;
         if (frame_clr) begin
            framed  <= 1'b0;
            bit_cnt <= '0;
            lost    <= 1'b0;
         end else if (scl_fall && !framed) begin
            framed <= 1'b1;
         end else if (bit_end) begin
            if (bit_cnt == ACK_SLOT) begin
               bit_cnt   <= '0;
               ack_bit   <= samp;
               ack_valid <= 1'b1;
               tx_full   <= 1'b0;
            end else begin
               shreg   <= {shreg[DATA_W-2:0], samp};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_DATA) rx_valid <= 1'b1;
            end
         end
         if (tx_load) begin
            shreg   <= tx_byte;
            tx_full <= 1'b1;
         end
      end
   end

   assign drive_tx  = tx_en & tx_full & ~lost & in_data & ~shreg[DATA_W-1];
   assign drive_ack = ~tx_en & framed & (bit_cnt == ACK_SLOT) & ack_en;
   assign sda_low   = drive_tx | drive_ack;
   assign rx_byte   = shreg;
endmodule

// File: rtl/i2cfe_front.sv
module i2cfe_front
   import i2cfe_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              low_power_i,
   input  logic              tx_en_i,
   input  logic              master_en_i,
   input  logic              ack_en_i,
   input  logic              tx_load_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              sda_low_o,
   output logic              start_o,
   output logic              rstart_o,
   output logic              stop_o,
   output logic              wake_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   output logic              ack_bit_o,
   output logic              ack_valid_o,
   output logic              arb_lost_o
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2cfe_front: DATA_W must be at least 2");
      end
   endgenerate

   logic [1:0] pins_s;
   cond_t      cond;
   logic       scl_rise, scl_fall, any_cond;

   i2cfe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_LVL(BUS_IDLE_LVL)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (pins_s)
   );

   i2cfe_cond u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (pins_s[1]),
      .sda_s      (pins_s[0]),
      .cond_o     (cond),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   assign any_cond = cond.start | cond.rstart | cond.stop;

   i2cfe_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (pins_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .frame_clr (any_cond),
      .tx_en     (tx_en_i),
      .master_en (master_en_i),
      .ack_en    (ack_en_i),
      .tx_load   (tx_load_i),
      .tx_byte   (tx_byte_i),
      .sda_low   (sda_low_o),
      .rx_byte   (rx_byte_o),
      .rx_valid  (rx_valid_o),
      .ack_bit   (ack_bit_o),
      .ack_valid (ack_valid_o),
      .arb_lost  (arb_lost_o)
   );

   assign start_o  = cond.start;
   assign rstart_o = cond.rstart;
   assign stop_o   = cond.stop;
   assign wake_o   = low_power_i & any_cond;
endmodule

// File: rtl/i2cfe_front_chk.sv
module i2cfe_front_chk (
   input logic clk,
   input logic rst_n,
   input logic low_power_i,
   input logic tx_en_i,
   input logic master_en_i,
   input logic sda_low_o,
   input logic start_o,
   input logic rstart_o,
   input logic stop_o,
   input logic wake_o,
   input logic rx_valid_o,
   input logic ack_valid_o,
   input logic arb_lost_o
);
   AST_ONE_COND: assert property (@(posedge clk) disable iff (!rst_n) $countones({start_o, rstart_o, stop_o}) <= 1); // R4
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) start_o |=> !start_o && !rstart_o); // R1
   AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) stop_o |=> !stop_o); // R4
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_o |=> !sda_low_o); // R3
   AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n) wake_o |-> low_power_i); // R5
   AST_ARB_GATE: assert property (@(posedge clk) disable iff (!rst_n) arb_lost_o |-> master_en_i && tx_en_i); // R9
   AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) arb_lost_o |=> !sda_low_o); // R9
   AST_RX_ACK_APART: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |-> !ack_valid_o); // R6
endmodule

bind i2cfe_front i2cfe_front_chk u_chk (.*);

// File: tb/i2cfe_front_bench.sv
module i2cfe_front_bench;
   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda_m = 1'b1;
   logic       low_power = 1'b0, tx_en = 1'b0, master_en = 1'b0, ack_en = 1'b0;
   logic       tx_load = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       sda_low, start_s, rstart_s, stop_s, wake_s, rx_valid, ack_bit, ack_valid, arb_lost;
   logic [7:0] rx_byte;
   wire        sda_bus = sda_m & ~sda_low;

   int checks = 0, fails = 0;
   int n_start = 0, n_rstart = 0, n_stop = 0, n_wake = 0, n_rx = 0, n_ack = 0, n_arb = 0;
   logic [7:0] cap_byte = 8'h00;
   logic       cap_ack = 1'b1;

   always #10 clk = ~clk;

   i2cfe_front u_i2cfe_front (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .low_power_i(low_power), .tx_en_i(tx_en), .master_en_i(master_en), .ack_en_i(ack_en),
      .tx_load_i(tx_load), .tx_byte_i(tx_byte), .sda_low_o(sda_low),
      .start_o(start_s), .rstart_o(rstart_s), .stop_o(stop_s), .wake_o(wake_s),
      .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .ack_bit_o(ack_bit),
      .ack_valid_o(ack_valid), .arb_lost_o(arb_lost)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (start_s)   n_start  <= n_start + 1;
         if (rstart_s)  n_rstart <= n_rstart + 1;
         if (stop_s)    n_stop   <= n_stop + 1;
         if (wake_s)    n_wake   <= n_wake + 1;
         if (arb_lost)  n_arb    <= n_arb + 1;
         if (rx_valid)  begin n_rx <= n_rx + 1; cap_byte <= rx_byte; end
         if (ack_valid) begin n_ack <= n_ack + 1; cap_ack <= ack_bit; end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b0; clks(H); scl = 1'b0; clks(H);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; clks(H); scl = 1'b1; clks(H); sda_m = 1'b0; clks(H); scl = 1'b0; clks(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; clks(H); scl = 1'b1; clks(H); sda_m = 1'b1; clks(H);
   endtask

   task automatic bus_bit(input logic b, output logic s);
      sda_m = b; clks(H); scl = 1'b1; clks(H); s = sda_bus; scl = 1'b0; clks(2);
   endtask

   task automatic xfer(input logic [7:0] drv, input logic ack_m, output logic [7:0] seen, output logic seen_ack);
      for (int i = 7; i >= 0; i--) bus_bit(drv[i], seen[i]);
      bus_bit(ack_m, seen_ack);
   endtask

   task automatic load(input logic [7:0] v);
      tx_byte = v; tx_load = 1'b1; clks(1); tx_load = 1'b0; clks(1);
   endtask

   initial begin : watchdog
      repeat (160000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] seen;
      logic       sa;
      int b_start, b_stop, b_rx, b_ack;
      clks(3);
      // R11: reset state
      chk("R11 strobes", {start_s, rstart_s, stop_s, wake_s, rx_valid, ack_valid, arb_lost}, 0);
      chk("R11 sda_low", sda_low, 0);
      rst_n = 1'b1; clks(4);
      chk("R11 after release", {sda_low, start_s, stop_s}, 0);

      // R6/R7: receive every byte, ACK control alternating
      for (int v = 0; v < 256; v++) begin
         ack_en = v[0];
         bus_start();
         xfer(v[7:0], 1'b1, seen, sa);
         bus_stop();
         chk("R6 rx_byte", cap_byte, v);
         chk("R7 data bits undriven", seen, v);
         chk("R7 ack slot level", sa, !v[0]);
      end
      chk("R1 start count", n_start, 256);
      chk("R3 stop count", n_stop, 256);
      chk("R6 rx_valid count", n_rx, 256);
      chk("R5 no wake when awake", n_wake, 0);
      chk("R2 no rstart", n_rstart, 0);

      // R8: transmit every byte against a released bus
      tx_en = 1'b1; ack_en = 1'b0;
      b_ack = n_ack;
      for (int v = 0; v < 256; v++) begin
         load(v[7:0]);
         bus_start();
         xfer(8'hFF, v[1], seen, sa);
         bus_stop();
         chk("R8 bus byte", seen, v);
         chk("R8 ack_bit", cap_ack, v[1]);
         chk("R8 ninth released", sa, v[1]);
      end
      chk("R8 ack_valid count", n_ack - b_ack, 256);
      chk("R9 no loss without master", n_arb, 0);

      // R2: repeated START inside a frame
      tx_en = 1'b0; b_start = n_start; b_rx = n_rx;
      bus_start();
      xfer(8'h5A, 1'b1, seen, sa);
      bus_rstart();
      xfer(8'hC3, 1'b1, seen, sa);
      chk("R6 byte after rstart", cap_byte, 8'hC3);
      bus_stop();
      chk("R2 rstart count", n_rstart, 1);
      chk("R2 single start", n_start - b_start, 1);
      chk("R6 two bytes", n_rx - b_rx, 2);

      // R10: SDA toggles under low SCL, idle bus
      b_start = n_start; b_stop = n_stop;
      scl = 1'b0; clks(H);
      for (int k = 0; k < 6; k++) begin sda_m = ~sda_m; clks(H); end
      sda_m = 1'b1; clks(H); scl = 1'b1; clks(H);
      chk("R10 no start", n_start - b_start, 0);
      chk("R10 no stop", n_stop - b_stop, 0);
      chk("R10 no rstart", n_rstart, 1);

      // R5: wake in low power
      low_power = 1'b1;
      bus_start(); bus_rstart(); bus_stop();
      low_power = 1'b0;
      chk("R5 wake count", n_wake, 3);

      // R9: lose arbitration as master: own 0xB0 vs other 0x8F
      tx_en = 1'b1; master_en = 1'b1;
      load(8'hB0);
      bus_start();
      xfer(8'h8F, 1'b1, seen, sa);
      bus_stop();
      chk("R9 arb pulse", n_arb, 1);
      chk("R9 released after loss", seen, 8'h8F);

      // R9: same contest without master role: no loss, wired AND on bus
      master_en = 1'b0;
      load(8'hB0);
      bus_start();
      xfer(8'h8F, 1'b1, seen, sa);
      bus_stop();
      chk("R9 no pulse off master", n_arb, 1);
      chk("R9 wired AND", seen, 8'h80);
      chk("R3 released after stop", sda_low, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule